// File: doc/BRIEF.md
# SMBus Bus Idle and Clock-Stall Monitor

This block watches the clock and data lines of a two-wire SMBus-style bus and reports two conditions. It flags a clock stall when SCL has stayed low for a set number of periods of a slow time base. It also raises a bus-idle level once both lines have stayed high for longer than a set number of such periods. Time is measured only in pulses of a periodic `tick` input, not in system clock cycles. The bus-idle detector therefore depends on that tick even when the surrounding interface acts only as a target.

Each raw line passes through a two-stage synchronizer before edges are found. Any falling edge on either line clears the idle state. A START condition is one such edge. A STOP condition can mark the bus idle at once. When the idle level rises while a controller START is waiting, the block emits a one-cycle strobe that lets that START proceed. The stall event is a single-cycle pulse. The logic around the block uses it to disable and then re-enable the interface.

Top module: `smb_idle_watch`

## Requirements
- R1: While `rst_n` is low, and directly after reset, `bus_free`, `low_evt` and `start_ok` are 0.
- R2: With `free_en` high and both lines high, `bus_free` rises after FREE_TICKS+1 tick pulses. FREE_TICKS pulses alone leave it low.
- R3: Clock cycles without a tick pulse do not advance either timer, however many of them pass.
- R4: A falling edge on SCL or SDA, which includes a START (SDA falling while SCL is high), drops `bus_free` and restarts the idle count from zero.
- R5: When STOP_FREES is 1, a STOP (SDA rising while SCL stays high) sets `bus_free` without waiting for ticks.
- R6: While `free_en` is low, `bus_free` is 0 and the idle count is held at zero. After `free_en` is raised again, a full FREE_TICKS+1 ticks are needed.
- R7: `start_ok` pulses for exactly one cycle in the cycle `bus_free` goes from 0 to 1, and only if `start_pend` was high. Otherwise it stays 0.
- R8: With `low_en` high and SCL low, `low_evt` pulses for one cycle on the LOW_TICKS-th tick. It does not pulse again during the same low period.
- R9: A rising edge on SCL clears the stall count, so the next low period needs a full LOW_TICKS ticks.
- R10: While `low_en` is low, `low_evt` stays 0 and the stall count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| tick | input | 1 | One-cycle pulse per time-base period |
| free_en | input | 1 | Enables bus-idle detection |
| low_en | input | 1 | Enables clock-stall detection |
| start_pend | input | 1 | A controller START is waiting for an idle bus |
| low_evt | output | 1 | One-cycle clock-stall event |
| bus_free | output | 1 | Bus is idle |
| start_ok | output | 1 | One-cycle strobe releasing a pending START |

## Verification
The bench builds the block with FREE_TICKS at 6 and LOW_TICKS at 5, with the default of 1 for STOP_FREES. These short windows put the exact threshold ticks on both timers within reach of a few tick pulses, so a count that is off by one in either direction shows up. They also leave room to repeat the stall detector's re-arm and once-per-period behaviour several times. With these values, sequences that toggle the enables and send START and STOP conditions between timeouts stay short. That in turn leaves room to check the release strobe in both the timeout path and the STOP path.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    // Synchronized view of one bus line.
    typedef struct packed {
        logic lvl;   // synchronized level
        logic rise;  // rose since last cycle
        logic fall;  // fell since last cycle
    } line_t;

    localparam int unsigned N_LINES = 2;
    localparam int unsigned IDX_SCL = 0;
    localparam int unsigned IDX_SDA = 1;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_mon_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  raw,
    output line_t line
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;   // an idle bus is high
        else        sh_q <= sh_d;
    end

    always_comb begin
        line.lvl  = sh_q[STAGES-1];
        line.rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        line.fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/smb_free_det.sv
module smb_free_det
    import smb_mon_pkg::*;
#(
    parameter int unsigned FREE_TICKS = 10,
    parameter bit          STOP_FREES = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t scl,
    input  line_t sda,
    input  logic  tick,
    input  logic  en,
    input  logic  start_pend,
    output logic  bus_free,
    output logic  start_ok
);
    localparam int unsigned CW = $clog2(FREE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(FREE_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          free;
        logic          ok;
    } st_t;

    st_t st_d, st_q;
    logic start_cond, stop_cond, any_fall, both_high;

    always_comb begin
        start_cond = sda.fall & scl.lvl & ~scl.fall;
        stop_cond  = sda.rise & scl.lvl & ~scl.rise;
        any_fall   = scl.fall | sda.fall;
        both_high  = scl.lvl & sda.lvl;

        st_d    = st_q;
        st_d.ok = 1'b0;
        if (!en || any_fall || start_cond) begin
            st_d.cnt  = '0;
            st_d.free = 1'b0;
        end else if (STOP_FREES && stop_cond) begin
            st_d.cnt  = '0;
            st_d.free = 1'b1;
        end else if (both_high) begin
            if (tick) begin
                if (st_q.cnt == LAST) st_d.free = 1'b1;
                else                  st_d.cnt  = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        st_d.ok = start_pend & st_d.free & ~st_q.free;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_free = st_q.free;
    assign start_ok = st_q.ok;
endmodule

// File: rtl/smb_low_det.sv
module smb_low_det #(
    parameter int unsigned LOW_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic tick,
    input  logic en,
    output logic low_evt
);
    localparam int unsigned LW = $clog2(LOW_TICKS + 1);
    localparam logic [LW-1:0] LAST = LW'(LOW_TICKS - 1);

    typedef struct packed {
        logic [LW-1:0] cnt;
        logic          fired;
        logic          evt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (!en || scl_rise || scl_lvl) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (tick && !st_q.fired) begin
            if (st_q.cnt == LAST) begin
                st_d.evt   = 1'b1;
                st_d.fired = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign low_evt = st_q.evt;
endmodule

// File: rtl/smb_idle_watch.sv
module smb_idle_watch
    import smb_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FREE_TICKS  = 10,
    parameter int unsigned LOW_TICKS   = 25,
    parameter bit          STOP_FREES  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tick,
    input  logic free_en,
    input  logic low_en,
    input  logic start_pend,
    output logic low_evt,
    output logic bus_free,
    output logic start_ok
);
    logic [N_LINES-1:0] raw;
    line_t              ln [N_LINES];
    logic               scl_s, sda_s;

    assign raw[IDX_SCL] = scl_in;
    assign raw[IDX_SDA] = sda_in;

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw[g]),
            .line (ln[g])
        );
    end

    assign scl_s = ln[IDX_SCL].lvl;
    assign sda_s = ln[IDX_SDA].lvl;

    smb_free_det #(.FREE_TICKS(FREE_TICKS), .STOP_FREES(STOP_FREES)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (ln[IDX_SCL]),
        .sda       (ln[IDX_SDA]),
        .tick      (tick),
        .en        (free_en),
        .start_pend(start_pend),
        .bus_free  (bus_free),
        .start_ok  (start_ok)
    );

    smb_low_det #(.LOW_TICKS(LOW_TICKS)) u_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (scl_s),
        .scl_rise(ln[IDX_SCL].rise),
        .tick    (tick),
        .en      (low_en),
        .low_evt (low_evt)
    );
endmodule

// File: rtl/smb_idle_watch_chk.sv
module smb_idle_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_s,
    input logic free_en,
    input logic low_en,
    input logic start_pend,
    input logic low_evt,
    input logic bus_free,
    input logic start_ok
);
    p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_evt |=> !low_evt);

    p_no_evt_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !low_en |=> !low_evt);

    p_free_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !free_en |=> !bus_free);

    p_free_lines_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> $past(scl_s && sda_s));

    p_ok_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> (bus_free && !$past(bus_free)));

    p_ok_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> $past(start_pend));

    p_ok_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !start_ok);
endmodule

bind smb_idle_watch smb_idle_watch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .free_en   (free_en),
    .low_en    (low_en),
    .start_pend(start_pend),
    .low_evt   (low_evt),
    .bus_free  (bus_free),
    .start_ok  (start_ok)
);

// File: tb/smb_idle_watch_tb.sv
module smb_idle_watch_tb;
    localparam int unsigned FT = 6;
    localparam int unsigned LT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, tick = 1'b0;
    logic free_en = 1'b0, low_en = 1'b0, start_pend = 1'b0;
    logic low_evt, bus_free, start_ok;

    int checks = 0, errors = 0;
    int low_seen = 0, ok_seen = 0;
    logic low_prev = 1'b0, ok_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smb_idle_watch #(.FREE_TICKS(FT), .LOW_TICKS(LT)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .tick(tick),
        .free_en(free_en), .low_en(low_en), .start_pend(start_pend),
        .low_evt(low_evt), .bus_free(bus_free), .start_ok(start_ok)
    );

    // Pulse counters and width checks (R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (low_evt) low_seen++;
            if (start_ok) ok_seen++;
            if (low_evt && low_prev) begin
                errors++;
                $display("FAIL R8: low_evt high 2 cycles, actual 1 expected 0");
            end
            if (start_ok && ok_prev) begin
                errors++;
                $display("FAIL R7: start_ok high 2 cycles, actual 1 expected 0");
            end
        end
        low_prev = low_evt;
        ok_prev  = start_ok;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    typedef struct packed {
        logic       scl, sda, fe, le, pend;
        logic [3:0] nt;
        logic       xfree;
        logic [1:0] xlow, xok;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1,1,1,1,0, 4'd6, 0, 2'd0, 2'd0, 4'd2},  // R2 six ticks: not yet
        '{1,1,1,1,0, 4'd1, 1, 2'd0, 2'd0, 4'd2},  // R2 seventh tick
        '{0,1,1,1,0, 4'd4, 0, 2'd0, 2'd0, 4'd4},  // R4 SCL fall drops idle
        '{0,1,1,1,0, 4'd1, 0, 2'd1, 2'd0, 4'd8},  // R8 fifth low tick
        '{0,1,1,1,0, 4'd3, 0, 2'd0, 2'd0, 4'd8},  // R8 once per low period
        '{1,1,1,1,0, 4'd0, 0, 2'd0, 2'd0, 4'd4},
        '{1,1,1,1,1, 4'd7, 1, 2'd0, 2'd1, 4'd7},  // R7 release on timeout
        '{1,0,1,1,1, 4'd0, 0, 2'd0, 2'd0, 4'd4},  // R4 START
        '{1,1,1,1,1, 4'd0, 1, 2'd0, 2'd1, 4'd5},  // R5 STOP, R7
        '{1,1,0,1,0, 4'd0, 0, 2'd0, 2'd0, 4'd6},  // R6 disable
        '{1,1,0,1,0, 4'd8, 0, 2'd0, 2'd0, 4'd6},
        '{1,1,1,1,0, 4'd7, 1, 2'd0, 2'd0, 4'd6},  // R6 full count again
        '{0,1,1,0,0, 4'd8, 0, 2'd0, 2'd0, 4'd10}, // R10 disabled
        '{0,1,1,1,0, 4'd5, 0, 2'd1, 2'd0, 4'd10},
        '{1,1,1,1,0, 4'd0, 0, 2'd0, 2'd0, 4'd9},
        '{0,1,1,1,0, 4'd4, 0, 2'd0, 2'd0, 4'd9},  // R9 count restarted
        '{0,1,1,1,0, 4'd1, 0, 2'd1, 2'd0, 4'd9}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk("R1", {29'd0, bus_free, low_evt, start_ok}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", {29'd0, bus_free, low_evt, start_ok}, 0);

        free_en = 1'b1;
        low_en  = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int l0, o0;
            @(negedge clk);
            free_en = VEC[v].fe; low_en = VEC[v].le; start_pend = VEC[v].pend;
            l0 = low_seen; o0 = ok_seen;
            scl_in = VEC[v].scl; sda_in = VEC[v].sda;
            repeat (4) @(negedge clk);
            pulses(int'(VEC[v].nt));
            repeat (3) @(negedge clk);
            checks++;
            if (bus_free != VEC[v].xfree || (low_seen - l0) != int'(VEC[v].xlow)
                || (ok_seen - o0) != int'(VEC[v].xok)) begin
                errors++;
                $display("FAIL R%0d vec %0d: actual free=%0d low=%0d ok=%0d expected free=%0d low=%0d ok=%0d",
                         VEC[v].req, v, bus_free, low_seen - l0, ok_seen - o0,
                         VEC[v].xfree, VEC[v].xlow, VEC[v].xok);
            end
        end

        // R3: many cycles without a tick do not advance the idle timer.
        start_pend = 1'b0;
        scl_in = 1'b1; sda_in = 1'b0;
        repeat (4) @(negedge clk);
        sda_in = 1'b1;       // STOP makes it free; then clear it with a START
        repeat (4) @(negedge clk);
        sda_in = 1'b0;
        repeat (4) @(negedge clk);
        scl_in = 1'b0;
        repeat (4) @(negedge clk);
        scl_in = 1'b1;
        repeat (4) @(negedge clk);
        sda_in = 1'b1;       // STOP again, then drop it via SCL fall
        repeat (4) @(negedge clk);
        scl_in = 1'b0;
        repeat (4) @(negedge clk);
        scl_in = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3", int'(bus_free), 0);
        pulses(FT + 1);
        repeat (3) @(negedge clk);
        chk("R3", int'(bus_free), 1);

        // R3 for the stall timer: SCL low without ticks.
        begin
            int l0;
            l0 = low_seen;
            scl_in = 1'b0;
            repeat (200) @(negedge clk);
            chk("R3", low_seen - l0, 0);
            pulses(LT);
            repeat (3) @(negedge clk);
            chk("R8", low_seen - l0, 1);
        end

        // R1: reset in the middle of activity.
        scl_in = 1'b1;
        repeat (4) @(negedge clk);
        pulses(FT + 1);
        repeat (3) @(negedge clk);
        chk("R2", int'(bus_free), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {29'd0, bus_free, low_evt, start_ok}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule